// File: doc/BRIEF.md
# Cold-Junction Array Monitor

This block watches a small ring of cold-junction temperature sensors placed around a terminal zone. It treats the readings as a test of whether the zone is isothermal, not as numbers to average. Each sensor delivers signed fixed-point readings with its own valid strobe. Once every sensor has reported, the block closes the set and checks each sensor against its two ring neighbours. A sensor that stays too far from them for a programmable number of consecutive sets is marked as an outlier. The block then reduces the remaining sensors to a weighted cold-junction estimate and a min, a max and a spread. From these it raises a gradient flag and reports whether the zone can be trusted (OK) or not (Degraded).

A state machine steps through five named states. COLLECT gathers readings. When every sensor has reported at least once, the transition set-complete leads to SCORE, which updates the per-sensor persistence counters. From SCORE the block always moves on to REDUCE, which forms the min, max, weighted sum and weight sum over the sensors that are not outliers. REDUCE leaves by one of two transitions. When the weight sum is non-zero, divide-start leads to DIVIDE, where an iterative restoring divider forms the quotient. When the weight sum is zero, no-weight leads straight to PUBLISH. DIVIDE moves on to PUBLISH on divide-done. PUBLISH registers all results and then returns to COLLECT.

Readings that arrive while the machine is outside COLLECT are dropped. All thresholds, weights and the persistence count are static register inputs.

Top module: `cjc_array_monitor`

## Requirements
- R1: After reset, res_valid_o, conf_ok_o, grad_flag_o, est_o, min_o, max_o, spread_o and outlier_o are all zero.
- R2: A set completes once every sensor has strobed at least once in COLLECT. A sensor that strobes again before the set completes overwrites its earlier reading. Each completed set produces exactly one single-cycle res_valid_o pulse. The outputs change only on the cycle of that pulse.
- R3: min_o and max_o are the signed minimum and maximum over the non-outlier sensors. spread_o is max_o minus min_o.
- R4: grad_flag_o is 1 exactly when spread_o is strictly greater than grad_thr_i.
- R5: est_o is the sum of weight times reading over the non-outlier sensors, divided by the sum of their weights and truncated toward zero. Sensor i has a 4-bit unsigned weight in weight_i[4i+3:4i]. A zero-weight sensor does not move est_o but still counts toward min_o and max_o.
- R6: The deviation of sensor i is |2*x[i] - x[i-1] - x[i+1]|, with indices taken around the ring. Each sensor has a saturating counter that increments on every set in which its deviation exceeds 2*dev_lim_i and clears on any set in which it does not. Bit i of outlier_o is 1 when that counter is non-zero and at least persist_i.
- R7: A sensor flagged in outlier_o is excluded from est_o, min_o and max_o of that same set.
- R8: When the non-outlier weights sum to zero, est_o, min_o, max_o, spread_o and grad_flag_o keep their previous values and conf_ok_o is 0. This includes the case where every sensor is an outlier.
- R9: The first estimate published after reset counts as unstable. Each later estimate is stable when its absolute change from the previously published estimate is at most step_lim_i.
- R10: conf_ok_o is 1 exactly when the set is not in the R8 case, grad_flag_o is 0 and the estimate is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data_i | input | N_SENS*DW | Sensor readings, signed, sensor i at [DW*i +: DW] |
| smp_valid_i | input | N_SENS | Per-sensor reading strobe |
| weight_i | input | N_SENS*WW | Per-sensor unsigned weight |
| grad_thr_i | input | DW | Spread threshold for the gradient flag |
| dev_lim_i | input | DW | Neighbour deviation limit |
| persist_i | input | CW | Consecutive sets needed to flag an outlier |
| step_lim_i | input | DW | Largest estimate change still counted as stable |
| res_valid_o | output | 1 | One-cycle pulse per completed set |
| est_o | output | DW | Weighted cold-junction estimate, signed |
| min_o | output | DW | Minimum non-outlier reading, signed |
| max_o | output | DW | Maximum non-outlier reading, signed |
| spread_o | output | DW+1 | max_o minus min_o |
| grad_flag_o | output | 1 | Spread above threshold |
| conf_ok_o | output | 1 | 1 = OK, 0 = Degraded |
| outlier_o | output | N_SENS | Per-sensor outlier flag |

## Verification
The bench runs a 64-set arithmetic sweep. Readings, weights and set-to-set steps all vary, so weighted rounding toward zero, zero-weight sensors and both stable and unstable steps occur, and the gradient threshold is crossed in both directions. Readings arrive in three patterns: all at once, one per cycle, or with one sensor repeated. These separate set completion from strobe order and show that a later reading overwrites an earlier one. A directed run places the spread exactly at the threshold and then one above it, which separates a strict comparison from a non-strict one. A persistent spike on one sensor shows that a single or double excursion is ignored, that the third one flags the sensor and removes it from the results, and that the flag clears when the spike stops. Setting all weights to zero shows that the results hold while confidence drops.

// File: rtl/cjc_pkg.sv
package cjc_pkg;
    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_SCORE,
        ST_REDUCE,
        ST_DIVIDE,
        ST_PUBLISH
    } mon_state_t;
endpackage

// File: rtl/cjc_persist.sv
// Per-sensor persistence counter: saturating count of consecutive excursions.
module cjc_persist #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          exceed,
    input  logic [CW-1:0] limit,
    output logic          flag
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            if (!exceed) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign flag = (cnt != '0) && (cnt >= limit);
endmodule

// File: rtl/cjc_divider.sv
// Iterative restoring divider on magnitudes, one quotient bit per cycle.
module cjc_divider #(
    parameter int NW  = 23,
    parameter int DVW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic           done,
    output logic [NW-1:0]  quotient
);
    localparam int CNTW = $clog2(NW + 1);

    logic            busy;
    logic [CNTW-1:0] cnt;
    logic [DVW-1:0]  rem;
    logic [DVW-1:0]  dvs;
    logic [NW-1:0]   quo;
    logic [DVW:0]    rem_sh;
    logic [DVW:0]    rem_nx;
    logic            ge;

    always_comb begin
        rem_sh = {rem, quo[NW-1]};
        ge     = rem_sh >= {1'b0, dvs};
        rem_nx = ge ? (rem_sh - {1'b0, dvs}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            rem  <= '0;
            dvs  <= '0;
            quo  <= '0;
            done <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNTW'(NW);
            rem  <= '0;
            dvs  <= divisor;
            quo  <= dividend;
            done <= 1'b0;
        end else if (busy) begin
            rem <= rem_nx[DVW-1:0];
            quo <= {quo[NW-2:0], ge};
            cnt <= cnt - 1'b1;
            if (cnt == CNTW'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo;
endmodule

// File: rtl/cjc_array_monitor.sv
module cjc_array_monitor
    import cjc_pkg::*;
#(
    parameter int N_SENS = 4,
    parameter int DW     = 16,
    parameter int WW     = 4,
    parameter int CW     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SENS*DW-1:0] smp_data_i,
    input  logic [N_SENS-1:0]    smp_valid_i,
    input  logic [N_SENS*WW-1:0] weight_i,
    input  logic [DW-1:0]        grad_thr_i,
    input  logic [DW-1:0]        dev_lim_i,
    input  logic [CW-1:0]        persist_i,
    input  logic [DW-1:0]        step_lim_i,
    output logic                 res_valid_o,
    output logic [DW-1:0]        est_o,
    output logic [DW-1:0]        min_o,
    output logic [DW-1:0]        max_o,
    output logic [DW:0]          spread_o,
    output logic                 grad_flag_o,
    output logic                 conf_ok_o,
    output logic [N_SENS-1:0]    outlier_o
);
    localparam int LGN  = $clog2(N_SENS);
    localparam int DVW  = WW + LGN;
    localparam int NUMW = DW + WW + LGN + 1;
    localparam int SPW  = DW + 1;
    localparam int DEVW = DW + 2;

    mon_state_t state, state_nx;

    logic signed [DW-1:0] samp [N_SENS];
    logic [N_SENS-1:0]    got;
    logic                 set_full;

    logic [N_SENS-1:0]    exceed;
    logic [N_SENS-1:0]    flag;

    logic signed [NUMW-1:0] num_c;
    logic [DVW-1:0]         wsum_c;
    logic signed [DW-1:0]   min_c, max_c;
    logic                   any_c;
    logic [NUMW-1:0]        num_abs;

    logic                   r_neg, r_none;
    logic signed [DW-1:0]   r_min, r_max;

    logic                   div_start, div_done;
    logic [NUMW-1:0]        quo;

    logic signed [DW-1:0]   est_q;
    logic                   prev_vld;
    logic signed [DW-1:0]   est_new;
    logic [SPW-1:0]         spread_new;
    logic                   grad_new;
    logic signed [DW:0]     step_d;
    logic [DW:0]            step_abs;
    logic                   stable;

    // ---------------- reading capture ----------------
    assign set_full = (state == ST_COLLECT) && (&(got | smp_valid_i));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got <= '0;
            for (int i = 0; i < N_SENS; i++) samp[i] <= '0;
        end else if (state == ST_COLLECT) begin
            for (int i = 0; i < N_SENS; i++) begin
                if (smp_valid_i[i]) samp[i] <= $signed(smp_data_i[DW*i +: DW]);
            end
            got <= set_full ? '0 : (got | smp_valid_i);
        end
    end

    // ---------------- neighbour deviation and persistence ----------------
    for (genvar i = 0; i < N_SENS; i++) begin : g_sens
        localparam int LFT = (i + N_SENS - 1) % N_SENS;
        localparam int RGT = (i + 1) % N_SENS;
        logic signed [DEVW-1:0] dev;
        logic [DEVW-1:0]        dev_abs;

        always_comb begin
            dev     = $signed({samp[i][DW-1], samp[i], 1'b0})
                      - DEVW'(samp[LFT]) - DEVW'(samp[RGT]);
            dev_abs = dev[DEVW-1] ? DEVW'(-dev) : DEVW'(dev);
            exceed[i] = dev_abs > DEVW'({dev_lim_i, 1'b0});
        end

        cjc_persist #(.CW(CW)) u_persist (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (state == ST_SCORE),
            .exceed (exceed[i]),
            .limit  (persist_i),
            .flag   (flag[i])
        );
    end

    // ---------------- reduction over included sensors ----------------
    always_comb begin
        num_c  = '0;
        wsum_c = '0;
        any_c  = 1'b0;
        min_c  = samp[0];
        max_c  = samp[0];
        for (int i = 0; i < N_SENS; i++) begin
            if (!flag[i]) begin
                wsum_c = wsum_c + DVW'(weight_i[WW*i +: WW]);
                num_c  = num_c + NUMW'(samp[i])
                               * NUMW'($signed({1'b0, weight_i[WW*i +: WW]}));
                if (!any_c) begin
                    min_c = samp[i];
                    max_c = samp[i];
                    any_c = 1'b1;
                end else begin
                    if (samp[i] < min_c) min_c = samp[i];
                    if (samp[i] > max_c) max_c = samp[i];
                end
            end
        end
        num_abs = num_c[NUMW-1] ? NUMW'(-num_c) : NUMW'(num_c);
    end

    assign div_start = (state == ST_REDUCE) && (wsum_c != '0);

    cjc_divider #(.NW(NUMW), .DVW(DVW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (num_abs),
        .divisor  (wsum_c),
        .done     (div_done),
        .quotient (quo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_neg  <= 1'b0;
            r_none <= 1'b0;
            r_min  <= '0;
            r_max  <= '0;
        end else if (state == ST_REDUCE) begin
            r_neg  <= num_c[NUMW-1];
            r_none <= (wsum_c == '0);
            r_min  <= min_c;
            r_max  <= max_c;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: if (set_full) state_nx = ST_SCORE;
            ST_SCORE:   state_nx = ST_REDUCE;
            ST_REDUCE:  state_nx = (wsum_c == '0) ? ST_PUBLISH : ST_DIVIDE;
            ST_DIVIDE:  if (div_done) state_nx = ST_PUBLISH;
            ST_PUBLISH: state_nx = ST_COLLECT;
            default:    state_nx = ST_COLLECT;
        endcase
    end

    // ---------------- publish-time evaluation ----------------
    always_comb begin
        est_new    = r_neg ? -$signed(quo[DW-1:0]) : $signed(quo[DW-1:0]);
        spread_new = SPW'({r_max[DW-1], r_max} - {r_min[DW-1], r_min});
        grad_new   = spread_new > SPW'(grad_thr_i);
        step_d     = {est_new[DW-1], est_new} - {est_q[DW-1], est_q};
        step_abs   = step_d[DW] ? (DW+1)'(-step_d) : (DW+1)'(step_d);
        stable     = prev_vld && (step_abs <= (DW+1)'(step_lim_i));
    end

    // ---------------- output registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            est_q       <= '0;
            min_o       <= '0;
            max_o       <= '0;
            spread_o    <= '0;
            grad_flag_o <= 1'b0;
            conf_ok_o   <= 1'b0;
            outlier_o   <= '0;
            prev_vld    <= 1'b0;
        end else if (state == ST_PUBLISH) begin
            res_valid_o <= 1'b1;
            outlier_o   <= flag;
            if (r_none) begin
                conf_ok_o <= 1'b0;
            end else begin
                est_q       <= est_new;
                min_o       <= r_min;
                max_o       <= r_max;
                spread_o    <= spread_new;
                grad_flag_o <= grad_new;
                conf_ok_o   <= !grad_new && stable;
                prev_vld    <= 1'b1;
            end
        end else begin
            res_valid_o <= 1'b0;
        end
    end

    assign est_o = est_q;
endmodule

// File: rtl/cjc_monitor_checker.sv
module cjc_monitor_checker #(
    parameter int N_SENS = 4,
    parameter int DW     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid_o,
    input logic [DW-1:0]     est_o,
    input logic [DW-1:0]     min_o,
    input logic [DW-1:0]     max_o,
    input logic              grad_flag_o,
    input logic              conf_ok_o,
    input logic [N_SENS-1:0] outlier_o
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(est_o) && $stable(conf_ok_o) && $stable(outlier_o)));

    a_r3_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> ($signed(min_o) <= $signed(max_o)));

    a_r5_est_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && conf_ok_o) |->
            (($signed(est_o) >= $signed(min_o)) && ($signed(est_o) <= $signed(max_o))));

    a_r8_all_out_degraded: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && (&outlier_o)) |-> !conf_ok_o);

    a_r10_ok_no_gradient: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && conf_ok_o) |-> !grad_flag_o);
endmodule

bind cjc_array_monitor cjc_monitor_checker #(.N_SENS(N_SENS), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid_o (res_valid_o),
    .est_o       (est_o),
    .min_o       (min_o),
    .max_o       (max_o),
    .grad_flag_o (grad_flag_o),
    .conf_ok_o   (conf_ok_o),
    .outlier_o   (outlier_o)
);

// File: tb/cjc_array_monitor_bench.sv
module cjc_array_monitor_bench;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int WW = 4;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*DW-1:0] smp_data = '0;
    logic [N-1:0]    smp_valid = '0;
    logic [N*WW-1:0] weight = '0;
    logic [DW-1:0]   grad_thr = '0;
    logic [DW-1:0]   dev_lim = '0;
    logic [CW-1:0]   persist = '0;
    logic [DW-1:0]   step_lim = '0;
    logic            res_valid;
    logic [DW-1:0]   est, mn, mx;
    logic [DW:0]     spread;
    logic            grad, conf;
    logic [N-1:0]    outl;

    always #2 clk = ~clk;

    cjc_array_monitor #(.N_SENS(N), .DW(DW), .WW(WW), .CW(CW)) u_cjc_array_monitor (
        .clk (clk), .rst_n (rst_n),
        .smp_data_i (smp_data), .smp_valid_i (smp_valid), .weight_i (weight),
        .grad_thr_i (grad_thr), .dev_lim_i (dev_lim), .persist_i (persist),
        .step_lim_i (step_lim),
        .res_valid_o (res_valid), .est_o (est), .min_o (mn), .max_o (mx),
        .spread_o (spread), .grad_flag_o (grad), .conf_ok_o (conf),
        .outlier_o (outl)
    );

    int nchk = 0;
    int nfail = 0;

    // model state
    int v [N];
    int w [N];
    int cnt [N];
    int pv = 0;
    bit pvld = 1'b0;
    int e_est = 0, e_min = 0, e_max = 0, e_spr = 0, e_grad = 0, e_ok = 0, e_mask = 0;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_weights(input int a, input int b, input int c, input int d);
        w[0] = a; w[1] = b; w[2] = c; w[3] = d;
        for (int i = 0; i < N; i++) weight[WW*i +: WW] = WW'(w[i]);
    endtask

    task automatic model();
        int wsum, num, lo, hi, dv;
        bit any;
        e_mask = 0; wsum = 0; num = 0; lo = 0; hi = 0; any = 1'b0;
        for (int i = 0; i < N; i++) begin
            dv = 2 * v[i] - v[(i + N - 1) % N] - v[(i + 1) % N];
            if (dv < 0) dv = -dv;
            if (dv > 2 * int'(dev_lim)) begin
                if (cnt[i] < 15) cnt[i]++;
            end else cnt[i] = 0;
            if (cnt[i] != 0 && cnt[i] >= int'(persist)) e_mask |= (1 << i);
        end
        for (int i = 0; i < N; i++) begin
            if (((e_mask >> i) & 1) == 0) begin
                wsum += w[i];
                num += w[i] * v[i];
                if (!any) begin lo = v[i]; hi = v[i]; any = 1'b1; end
                else begin
                    if (v[i] < lo) lo = v[i];
                    if (v[i] > hi) hi = v[i];
                end
            end
        end
        if (wsum == 0) begin
            e_ok = 0;
        end else begin
            int d;
            e_est = num / wsum;
            e_min = lo; e_max = hi; e_spr = hi - lo;
            e_grad = (e_spr > int'(grad_thr)) ? 1 : 0;
            d = e_est - pv; if (d < 0) d = -d;
            e_ok = (e_grad == 0 && pvld && d <= int'(step_lim)) ? 1 : 0;
            pv = e_est; pvld = 1'b1;
        end
    endtask

    // mode 0: all at once; 1: one per cycle; 2: sensor 1 sends junk first
    task automatic send_set(input int a, input int b, input int c, input int d, input int mode);
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        @(negedge clk);
        if (mode == 1) begin
            for (int i = N - 1; i >= 0; i--) begin
                smp_data = '0;
                smp_data[DW*i +: DW] = DW'(v[i]);
                smp_valid = '0; smp_valid[i] = 1'b1;
                @(negedge clk);
            end
        end else begin
            if (mode == 2) begin
                smp_data = '0;
                smp_data[DW*1 +: DW] = DW'(12345);
                smp_valid = 4'b0010;
                @(negedge clk);
            end
            for (int i = 0; i < N; i++) smp_data[DW*i +: DW] = DW'(v[i]);
            smp_valid = '1;
            @(negedge clk);
        end
        smp_valid = '0;
    endtask

    task automatic wait_check(input string tag);
        int t;
        t = 0;
        while (res_valid !== 1'b1 && t < 200) begin
            @(negedge clk);
            t++;
        end
        model();
        chk({tag, " R2 result pulse"}, int'(res_valid), 1);
        chk({tag, " R5 estimate"}, int'($signed(est)), e_est);
        chk({tag, " R3 min"}, int'($signed(mn)), e_min);
        chk({tag, " R3 max"}, int'($signed(mx)), e_max);
        chk({tag, " R3 spread"}, int'(spread), e_spr);
        chk({tag, " R4 gradient"}, int'(grad), e_grad);
        chk({tag, " R10 confidence"}, int'(conf), e_ok);
        chk({tag, " R6 outliers"}, int'(outl), e_mask);
        @(negedge clk);
        chk({tag, " R2 single pulse"}, int'(res_valid), 0);
    endtask

    task automatic run_set(input int a, input int b, input int c, input int d,
                           input int mode, input string tag);
        send_set(a, b, c, d, mode);
        wait_check(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) cnt[i] = 0;
        set_weights(1, 1, 1, 1);
        grad_thr = 16'd40; dev_lim = 16'd300; persist = 4'd3; step_lim = 16'd20;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", int'(res_valid), 0);
        chk("R1 conf", int'(conf), 0);
        chk("R1 est", int'(est), 0);
        chk("R1 outliers", int'(outl), 0);
        chk("R1 spread", int'(spread), 0);

        // R9: first estimate is unstable even though spread is zero
        run_set(100, 100, 100, 100, 0, "first R9");
        // R5 truncation toward zero on a negative mean
        run_set(-7, -8, -8, -8, 0, "negtrunc R5");

        // R4 boundary: spread exactly at threshold, then one above
        run_set(0, 10, 20, 40, 1, "thr_eq R4");
        run_set(0, 10, 20, 41, 1, "thr_gt R4");

        // R2 overwrite by a later reading
        run_set(5, 6, 7, 8, 2, "overwrite R2");

        // arithmetic sweep with varying weights and strobe patterns
        for (int k = 0; k < 64; k++) begin
            int base;
            set_weights(k % 5, (k + 3) % 5, (k + 6) % 5, (k + 9) % 5);
            base = (k % 16) * 6 - 40;
            run_set(base + (k * 37) % 61 - 30, base + (k * 37 + 11) % 61 - 30,
                    base + (k * 37 + 44) % 61 - 30, base + (k * 37 + 99) % 61 - 30,
                    k % 3, "sweep R5 R9");
        end

        // R6 R7: persistent spike on sensor 2
        set_weights(2, 1, 3, 1);
        run_set(50, 52, 50, 51, 0, "settle R9");
        run_set(50, 52, 1050, 51, 0, "spike1 R6");
        run_set(50, 52, 1050, 51, 1, "spike2 R6");
        run_set(50, 52, 1050, 51, 2, "spike3 R7");
        run_set(50, 52, 1050, 51, 0, "spike4 R7");
        run_set(50, 52, 50, 51, 0, "clear R6");

        // R8: all weights zero -> hold results, degraded
        set_weights(0, 0, 0, 0);
        run_set(-300, 200, 0, 90, 0, "noweight R8");
        set_weights(1, 2, 1, 2);
        run_set(50, 52, 50, 51, 0, "recover R10");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule